// File: doc/BRIEF.md
# Prime-Modulo Interleaved Bank Controller

This block spreads a flat word address space over a prime number of storage banks, so that strided access streams land on different banks instead of queueing on one. The bank count is `2^BANK_K - 1`, and the bank is picked as the address modulo that count. The remainder comes from adding up the address's `BANK_K`-bit digits and folding the sum, so no divider is needed. Each bank is `2^DEPTH_W` words deep. The location inside the bank is just the low `DEPTH_W` address bits, which is the address modulo the depth. The bank count is odd and the depth is a power of two, so the two are co-prime. Every address below `NB*DEPTH` therefore owns a distinct (bank, location) pair.

Each bank models a fixed access time. A bank that takes a request stays unavailable for `ACC_CYC` cycles. Each bank runs a two-state machine, `B_IDLE` and `B_BUSY`. Its transitions are:
- `issue`: `B_IDLE` to `B_BUSY`, taken when the bank accepts a request and `ACC_CYC > 1`.
- `expire`: `B_BUSY` to `B_IDLE`, taken when the countdown runs out.
- `hold`: the bank stays in its current state on any other cycle.

`req_ready` reflects the state of the bank that the presented address selects. A request to a busy bank is held off. An accepted request returns a response after a fixed latency of `LAT = ADDR_CYC + ACC_CYC + RET_CYC` cycles. Because every request takes the same time, responses come back in acceptance order. Each response echoes the request's address as its tag.

Top module: `prime_bank_ctrl`

## Requirements
- R1: The bank for a request is `req_addr mod NB`, with `NB = 2^BANK_K - 1` (3 by default). For example, address 8 goes to bank 2, address 16 to bank 1 and address 11 to bank 2.
- R2: The location inside a bank is `req_addr[DEPTH_W-1:0]`. Every address from 0 to `NB*2^DEPTH_W - 1` keeps its own data, independent of all the others.
- R3: A bank that accepts a request in cycle c holds `req_ready` low for requests addressed to it until cycle `c + ACC_CYC`, and accepts again in that cycle. By default a sequential stream therefore waits 3 cycles at every wrap back to bank 0, and a request to the same bank issued right after another waits 5 cycles.
- R4: Requests to different idle banks are accepted in consecutive cycles without any wait.
- R5: A request accepted in cycle c produces `rsp_valid` in cycle `c + LAT` (8 by default). `rsp_addr` carries the request's address.
- R6: A read response carries the data most recently written to that address. A write response carries the data just written.
- R7: There is exactly one response per accepted request, in acceptance order. `rsp_write` echoes the request's `req_write`, and `rsp_valid` is low in every other cycle.
- R8: After reset every bank is idle, so `req_ready` is high, and `rsp_valid` is low.
- R9: A request presented while its bank is busy and then withdrawn has no effect. In particular, such a write leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | The bank selected by `req_addr` is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_write | output | 1 | Kind of the request being answered |
| rsp_addr | output | ADDR_W | Address tag of the request being answered |
| rsp_rdata | output | DATA_W | Read data, or the written data for a write |

## Verification
The bench builds the block with its defaults: three banks of eight words, a six-cycle bank access and an eight-cycle latency. In this configuration the bank count is smaller than the access time, so a plain sequential stream must stall at every wrap back to bank 0. The bench checks the exact number of waits at those wraps. The 24-word space is small enough to write every address and then read all of them back in a stride-7 order, which exercises the one-to-one mapping in full. Pairs of addresses that share a bank, and pairs that do not, are also reachable within a few cycles. This lets the bench check the held-off and back-to-back cases directly against a behavioural model of per-bank free times and a queue of pending responses.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    typedef enum logic {
        B_IDLE = 1'b0,
        B_BUSY = 1'b1
    } bank_st_e;
endpackage

// File: rtl/pbc_modfold.sv
// Remainder modulo 2^K-1 by digit summation and end-around folding.
module pbc_modfold #(
    parameter int ADDR_W = 5,
    parameter int K      = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [K-1:0]      rem_o
);
    localparam int ND    = (ADDR_W + K - 1) / K;
    localparam int SUM_W = K + $clog2(ND + 1) + 1;
    localparam logic [SUM_W-1:0] MOD_M = SUM_W'((1 << K) - 1);

    logic [ND*K-1:0]  pad;
    logic [SUM_W-1:0] acc;

    always_comb begin
        pad = '0;
        pad[ADDR_W-1:0] = addr_i;
        acc = '0;
        for (int i = 0; i < ND; i++) begin
            acc = acc + SUM_W'(pad[i*K +: K]);
        end
        for (int j = 0; j < SUM_W; j++) begin
            acc = (acc & MOD_M) + (acc >> K);
        end
        rem_o = (acc == MOD_M) ? '0 : acc[K-1:0];
    end
endmodule

// File: rtl/pbc_bank.sv
// One bank: idle/busy state machine with countdown, plus its word storage.
module pbc_bank
    import pbc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DEPTH_W = 3,
    parameter int ACC_CYC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_i,
    input  logic               wr_i,
    input  logic [DEPTH_W-1:0] off_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic               idle_o,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int DEPTH = 1 << DEPTH_W;
    localparam int CNT_W = $clog2(ACC_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(ACC_CYC - 1);

    bank_st_e           st, st_nx;
    logic [CNT_W-1:0]   cnt, cnt_nx;
    logic [DATA_W-1:0]  mem [DEPTH];
    logic [DATA_W-1:0]  rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= B_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            B_IDLE: begin
                if (acc_i && (ACC_CYC > 1)) begin
                    st_nx  = B_BUSY;
                    cnt_nx = RELOAD;
                end
            end
            B_BUSY: begin
                if (cnt <= CNT_W'(1)) begin
                    st_nx  = B_IDLE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        idle_o  = (st == B_IDLE);
        rdata_o = rd_q;
    end

    always_ff @(posedge clk) begin
        if (acc_i) begin
            if (wr_i) begin
                mem[off_i] <= wdata_i;
                rd_q       <= wdata_i;
            end else begin
                rd_q <= mem[off_i];
            end
        end
    end

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && (ACC_CYC > 1)) |=> !idle_o);

    // R3
    acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |-> idle_o);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RELOAD);
endmodule

// File: rtl/prime_bank_ctrl.sv
module prime_bank_ctrl #(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int BANK_K   = 2,
    parameter int DEPTH_W  = 3,
    parameter int ADDR_CYC = 1,
    parameter int ACC_CYC  = 6,
    parameter int RET_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_write,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int NB  = (1 << BANK_K) - 1;
    localparam int LAT = ADDR_CYC + ACC_CYC + RET_CYC;

    logic [BANK_K-1:0] sel;
    logic              accept;
    logic [NB-1:0]     idle;
    logic [DATA_W-1:0] brd [NB];

    logic              pv [LAT];
    logic              pw [LAT];
    logic [ADDR_W-1:0] pa [LAT];
    logic [BANK_K-1:0] pb [LAT];
    logic [DATA_W-1:0] pd [LAT];

    pbc_modfold #(.ADDR_W(ADDR_W), .K(BANK_K)) u_fold (
        .addr_i (req_addr),
        .rem_o  (sel)
    );

    assign req_ready = idle[sel];
    assign accept    = req_valid && req_ready;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        pbc_bank #(
            .DATA_W  (DATA_W),
            .DEPTH_W (DEPTH_W),
            .ACC_CYC (ACC_CYC)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_i   (accept && (sel == BANK_K'(g))),
            .wr_i    (req_write),
            .off_i   (req_addr[DEPTH_W-1:0]),
            .wdata_i (req_wdata),
            .idle_o  (idle[g]),
            .rdata_o (brd[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                pv[i] <= 1'b0;
                pw[i] <= 1'b0;
                pa[i] <= '0;
                pb[i] <= '0;
                pd[i] <= '0;
            end
        end else begin
            pv[0] <= accept;
            pw[0] <= req_write;
            pa[0] <= req_addr;
            pb[0] <= sel;
            pd[0] <= '0;
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1];
                pw[i] <= pw[i-1];
                pa[i] <= pa[i-1];
                pb[i] <= pb[i-1];
                pd[i] <= (i == 1) ? brd[pb[0]] : pd[i-1];
            end
        end
    end

    always_comb begin
        rsp_valid = pv[LAT-1];
        rsp_write = pw[LAT-1];
        rsp_addr  = pa[LAT-1];
        rsp_rdata = pd[LAT-1];
    end

    // R1
    mod_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (int'(sel) == (int'(req_addr) % NB)));

    // R5
    rsp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (int'(pb[LAT-1]) == (int'(rsp_addr) % NB)));
endmodule

// File: tb/prime_bank_ctrl_tb.sv
module prime_bank_ctrl_tb;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int NB     = 3;
    localparam int DEPTH  = 8;
    localparam int ACC    = 6;
    localparam int LAT    = 8;
    localparam int SPAN   = NB * DEPTH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_write;
    logic [ADDR_W-1:0] rsp_addr;
    logic [DATA_W-1:0] rsp_rdata;

    prime_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write),
        .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;
    string data_tag = "R6";

    int               free_at [NB];
    logic [DATA_W-1:0] mm [SPAN];
    int               q_due [$];
    int               q_addr [$];
    bit               q_wr [$];
    logic [DATA_W-1:0] q_dat [$];
    int               last_addr = -1;
    logic [DATA_W-1:0] last_data = '0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit w, input int a,
                        input logic [DATA_W-1:0] d, output bit took);
        bit er;
        @(negedge clk);
        req_valid = v;
        req_write = w;
        req_addr  = ADDR_W'(a);
        req_wdata = d;
        #1;
        er = (free_at[a % NB] <= cyc);
        chk(req_ready == er, "R3", "ready", req_ready, er);
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            chk(rsp_valid == 1'b1, "R5", "rsp_valid", rsp_valid, 1);
            chk(rsp_addr == ADDR_W'(q_addr[0]), "R5", "rsp_addr", rsp_addr, q_addr[0]);
            chk(rsp_write == q_wr[0], "R7", "rsp_write", rsp_write, q_wr[0]);
            chk(rsp_rdata == q_dat[0], data_tag, "rsp_rdata", rsp_rdata, q_dat[0]);
            last_addr = int'(rsp_addr);
            last_data = rsp_rdata;
            void'(q_due.pop_front());
            void'(q_addr.pop_front());
            void'(q_wr.pop_front());
            void'(q_dat.pop_front());
        end else begin
            chk(rsp_valid == 1'b0, "R7", "idle rsp_valid", rsp_valid, 0);
        end
        took = v && er;
        if (took) begin
            free_at[a % NB] = cyc + ACC;
            if (w) mm[a] = d;
            q_due.push_back(cyc + LAT);
            q_addr.push_back(a);
            q_wr.push_back(w);
            q_dat.push_back(mm[a]);
        end
        @(posedge clk);
        cyc++;
    endtask

    task automatic issue(input bit w, input int a, input logic [DATA_W-1:0] d,
                         output int waits);
        bit took;
        waits = 0;
        for (int n = 0; n < 64; n++) begin
            step(1'b1, w, a, d, took);
            if (took) break;
            waits++;
        end
    endtask

    task automatic idle(input int n);
        bit took;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, '0, took);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w;
        bit t;
        logic [DATA_W-1:0] orig;
        int seed;
        for (int b = 0; b < NB; b++) free_at[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", rsp_valid, 0);
        chk(req_ready == 1'b1, "R8", "ready after reset", req_ready, 1);
        @(posedge clk);

        // R3 / R1: sequential write stream stalls at every return to bank 0
        for (int a = 0; a < SPAN; a++) begin
            issue(1'b1, a, DATA_W'(16'hA000 + a * 37), w);
            if (a >= NB && (a % NB) == 0)
                chk(w == 3, "R3", "seq wrap waits", w, 3);
            else
                chk(w == 0, "R1", "seq waits", w, 0);
        end
        idle(LAT + 2);

        // R4 / R1: addresses 8,16,0 sit in banks 2,1,0
        issue(1'b0, 8, '0, w);
        chk(w == 0, "R4", "addr 8 waits", w, 0);
        issue(1'b0, 16, '0, w);
        chk(w == 0, "R4", "addr 16 waits", w, 0);
        issue(1'b0, 0, '0, w);
        chk(w == 0, "R4", "addr 0 waits", w, 0);
        issue(1'b0, 11, '0, w);
        chk(w == 3, "R1", "addr 11 shares bank with 8", w, 3);
        idle(LAT + 2);

        // R9: withdrawn write to a busy bank leaves data intact
        orig = mm[6];
        issue(1'b0, 3, '0, w);
        step(1'b1, 1'b1, 6, 16'hDEAD, t);
        chk(t == 1'b0, "R9", "write held off", t, 0);
        idle(8);
        issue(1'b0, 6, '0, w);
        idle(LAT + 2);
        chk(last_addr == 6 && last_data == orig, "R9", "addr 6 data", last_data, orig);

        // R2: stride-7 read-back of every address
        data_tag = "R2";
        for (int i = 0; i < SPAN; i++) issue(1'b0, (i * 7) % SPAN, '0, w);
        idle(LAT + 2);
        data_tag = "R6";

        // R6 / R3: read right after write to the same word
        issue(1'b1, 5, 16'h5A5A, w);
        issue(1'b0, 5, '0, w);
        chk(w == 5, "R3", "same-bank waits", w, 5);
        idle(LAT + 2);
        chk(last_addr == 5 && last_data == 16'h5A5A, "R6", "read after write", last_data, 16'h5A5A);

        // R7 / R6: mixed traffic
        seed = 13;
        for (int i = 0; i < 60; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            issue(((seed >> 8) & 1) == 1, (seed >> 12) % SPAN, DATA_W'(seed >> 3), w);
            if (((seed >> 20) & 3) == 0) idle(2);
        end
        idle(LAT + 2);
        chk(q_due.size() == 0, "R7", "pending responses", q_due.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule